// File: doc/BRIEF.md
# Dual-Bank Configuration Register File

This block keeps two full copies of a device's configuration state, a foreground bank and a background bank. Each bank holds four 16-bit words: a control word, a segment-control word, an address pointer and a mask word. Two select commands switch between the banks, so software can leave a long-running setup in one bank, do short work in the other, and then return without reloading anything. Writes and reads reach only the bank that is active at that moment.

A write to the control word does one of two things, depending on its most significant bit. When that bit is 0, the write is a soft reset: every register in both banks returns to its reset value, the foreground bank becomes active, and the rest of the written value is discarded. When the bit is 1, the value is stored and a one-cycle compare-trigger pulse is raised for the external compare engine. The active control word is also decoded into three settings that the surrounding logic uses: a CAM/RAM partition code, a compare-mask choice and an address-step mode.

Top module: `cfgbank_regfile`

## Requirements
- R1: After reset (`rst_n` low), the foreground bank is active (`active_bg`=0), and `cmp_trig`=0. In both banks the control, address and mask words are 0 and the segment-control word equals `SEG_INIT` (default 16'h00C3).
- R2: A cycle with `sel_bg` high and `sel_fg` low makes the background bank active from the next cycle on. `sel_fg` high with `sel_bg` low makes the foreground bank active. When both are high, the active bank does not change.
- R3: A write (`wr_en` high, `wr_sel` 0=control, 1=segment control, 2=address, 3=mask) changes only the bank that is active in the cycle of the write, including when a select command is given in that same cycle. `rd_data` shows the word chosen by `rd_sel` from the active bank.
- R4: A control write whose bit 15 is 0 returns both banks to their R1 values and makes the foreground bank active. The other bits of that write are ignored and no `cmp_trig` pulse follows.
- R5: A control write whose bit 15 is 1 stores the value. `cmp_trig` is then high for exactly the one cycle after the write edge. Writes to the other three words never raise `cmp_trig`.
- R6: Bit 15 of the control word always reads back as 0. Bits 14:0 read back as written.
- R7: `mask_sel` decodes control bits 5:4: 01 gives 01 (mask 1), 10 gives 10 (mask 2), and 00 or 11 give 00 (no mask).
- R8: `addr_mode` decodes control bits 3:2: 01 gives 01 (increment), 10 gives 10 (decrement), and 00 or 11 give 00 (hold).
- R9: `part_code` equals bits 8:6 of the active control word.
- R10: After a bank switch, `part_code`, `mask_sel` and `addr_mode` reflect the control word of the newly active bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_fg | input | 1 | Command: make the foreground bank active |
| sel_bg | input | 1 | Command: make the background bank active |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 2 | Write target: 0 control, 1 segment control, 2 address, 3 mask |
| wr_data | input | 16 | Write value |
| rd_sel | input | 2 | Read source, same coding as wr_sel |
| rd_data | output | 16 | Word read from the active bank |
| active_bg | output | 1 | 1 when the background bank is active |
| cmp_trig | output | 1 | One-cycle compare trigger |
| part_code | output | 3 | CAM/RAM partition code |
| mask_sel | output | 2 | Compare mask choice |
| addr_mode | output | 2 | Address step mode |

## Verification
The hardest case to reach is a collision of commands in one cycle. This covers a write issued in the same cycle as a bank switch, and a soft reset that must clear the bank that is *not* active. The stimulus handles the first case by asserting a select command and a write on the same clock edge, then reading back both banks. For the second, it fills the background bank with distinctive values, switches to the foreground bank, issues the soft reset there, and then switches back to confirm that the background values are gone.

// File: rtl/cfgbank_pkg.sv
package cfgbank_pkg;
    localparam int CFG_W  = 16;
    localparam int NBANK  = 2;
    localparam int TOP_B  = CFG_W - 1;

    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_SEG  = 2'd1,
        SEL_ADDR = 2'd2,
        SEL_MASK = 2'd3
    } cfg_sel_e;

    typedef struct packed {
        logic [CFG_W-1:0] ctrl;
        logic [CFG_W-1:0] seg;
        logic [CFG_W-1:0] addr;
        logic [CFG_W-1:0] mask;
    } cfg_set_t;
endpackage

// File: rtl/cfgbank_set.sv
module cfgbank_set
    import cfgbank_pkg::*;
#(
    parameter logic [CFG_W-1:0] SEG_INIT = 16'h00C3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             we,
    input  logic [1:0]       sel,
    input  logic [CFG_W-1:0] wdata,
    output cfg_set_t         regs
);
    localparam cfg_set_t RST_VAL = '{ctrl: '0, seg: SEG_INIT, addr: '0, mask: '0};

    cfg_set_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (clr) begin
            regs_d = RST_VAL;
        end else if (we) begin
            unique case (cfg_sel_e'(sel))
                SEL_CTRL: regs_d.ctrl = wdata;
                SEL_SEG:  regs_d.seg  = wdata;
                SEL_ADDR: regs_d.addr = wdata;
                SEL_MASK: regs_d.mask = wdata;
                default:  regs_d = regs_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= RST_VAL;
        else        regs_q <= regs_d;
    end

    assign regs = regs_q;

    AST_CLR_RESTORES: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (regs_q == RST_VAL)); // R4
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !we) |=> $stable(regs_q)); // R3
endmodule

// File: rtl/cfgbank_decode.sv
module cfgbank_decode
    import cfgbank_pkg::*;
(
    input  logic [CFG_W-1:0] ctrl,
    output logic [2:0]       part_code,
    output logic [1:0]       mask_sel,
    output logic [1:0]       addr_mode
);
    logic [1:0] mask_raw;
    logic [1:0] mode_raw;

    always_comb begin
        part_code = ctrl[8:6];
        mask_raw  = ctrl[5:4];
        mode_raw  = ctrl[3:2];
        mask_sel  = (mask_raw == 2'b01 || mask_raw == 2'b10) ? mask_raw : 2'b00;
        addr_mode = (mode_raw == 2'b01 || mode_raw == 2'b10) ? mode_raw : 2'b00;
    end
endmodule

// File: rtl/cfgbank_regfile.sv
module cfgbank_regfile
    import cfgbank_pkg::*;
#(
    parameter logic [15:0] SEG_INIT = 16'h00C3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sel_fg,
    input  logic        sel_bg,
    input  logic        wr_en,
    input  logic [1:0]  wr_sel,
    input  logic [15:0] wr_data,
    input  logic [1:0]  rd_sel,
    output logic [15:0] rd_data,
    output logic        active_bg,
    output logic        cmp_trig,
    output logic [2:0]  part_code,
    output logic [1:0]  mask_sel,
    output logic [1:0]  addr_mode
);
    typedef struct packed {
        logic bg;
        logic trig;
    } top_state_t;

    top_state_t st_d, st_q;
    logic       ctrl_wr_d, soft_rst_d;
    logic [NBANK-1:0] bank_we_d;
    cfg_set_t   sets [NBANK];
    cfg_set_t   act;

    always_comb begin
        st_d       = st_q;
        ctrl_wr_d  = wr_en && (cfg_sel_e'(wr_sel) == SEL_CTRL);
        soft_rst_d = ctrl_wr_d && !wr_data[TOP_B];
        st_d.trig  = ctrl_wr_d && wr_data[TOP_B];
        if (soft_rst_d)            st_d.bg = 1'b0;
        else if (sel_bg && !sel_fg) st_d.bg = 1'b1;
        else if (sel_fg && !sel_bg) st_d.bg = 1'b0;
        for (int b = 0; b < NBANK; b++)
            bank_we_d[b] = wr_en && !soft_rst_d && (int'(st_q.bg) == b);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar g = 0; g < NBANK; g++) begin : g_bank
        cfgbank_set #(.SEG_INIT(SEG_INIT)) i_set (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (soft_rst_d),
            .we    (bank_we_d[g]),
            .sel   (wr_sel),
            .wdata (wr_data),
            .regs  (sets[g])
        );
    end

    assign act = sets[st_q.bg];

    always_comb begin
        unique case (cfg_sel_e'(rd_sel))
            SEL_CTRL: rd_data = {1'b0, act.ctrl[TOP_B-1:0]};
            SEL_SEG:  rd_data = act.seg;
            SEL_ADDR: rd_data = act.addr;
            SEL_MASK: rd_data = act.mask;
            default:  rd_data = '0;
        endcase
    end

    cfgbank_decode i_dec (
        .ctrl      (act.ctrl),
        .part_code (part_code),
        .mask_sel  (mask_sel),
        .addr_mode (addr_mode)
    );

    assign active_bg = st_q.bg;
    assign cmp_trig  = st_q.trig;

    AST_TRIG_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'd0 && wr_data[15]) |=> cmp_trig); // R5
    AST_TRIG_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_trig |-> $past(wr_en && wr_sel == 2'd0 && wr_data[15])); // R5
    AST_SOFTRST_TO_FG: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'd0 && !wr_data[15]) |=> (!active_bg && !cmp_trig)); // R4
    AST_BG_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_bg && !sel_fg && !(wr_en && wr_sel == 2'd0)) |=> active_bg); // R2
    AST_BOTH_SELECT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_bg && sel_fg && !(wr_en && wr_sel == 2'd0)) |=> $stable(active_bg)); // R2
    AST_CTRL_TOPBIT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_sel == 2'd0) |-> !rd_data[15]); // R6
    AST_MASK_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        mask_sel != 2'b11); // R7
    AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        addr_mode != 2'b11); // R8
endmodule

// File: tb/test_cfgbank_regfile.sv
module test_cfgbank_regfile;
    localparam logic [15:0] SEG_RST = 16'h00C3;

    logic        clk = 0, rst_n = 0;
    logic        sel_fg = 0, sel_bg = 0, wr_en = 0;
    logic [1:0]  wr_sel = 0, rd_sel = 0;
    logic [15:0] wr_data = 0, rd_data;
    logic        active_bg, cmp_trig;
    logic [2:0]  part_code;
    logic [1:0]  mask_sel, addr_mode;
    int n_chk = 0, n_bad = 0;

    always #5 clk = ~clk;

    cfgbank_regfile i_cfgbank_regfile (
        .clk(clk), .rst_n(rst_n), .sel_fg(sel_fg), .sel_bg(sel_bg),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel),
        .rd_data(rd_data), .active_bg(active_bg), .cmp_trig(cmp_trig),
        .part_code(part_code), .mask_sel(mask_sel), .addr_mode(addr_mode)
    );

    task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [1:0] s, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1; wr_sel = s; wr_data = d;
        @(posedge clk); #1;
        wr_en = 0;
    endtask

    task automatic pick(input logic fg, input logic bg);
        @(negedge clk);
        sel_fg = fg; sel_bg = bg;
        @(posedge clk); #1;
        sel_fg = 0; sel_bg = 0;
    endtask

    task automatic rd(input logic [1:0] s, output logic [15:0] v);
        rd_sel = s; #1; v = rd_data;
    endtask

    task automatic t_reset;
        logic [15:0] v;
        chk("R1 active_bg", 16'(active_bg), 16'h0);
        chk("R1 cmp_trig", 16'(cmp_trig), 16'h0);
        rd(2'd0, v); chk("R1 ctrl", v, 16'h0);
        rd(2'd1, v); chk("R1 seg", v, SEG_RST);
        rd(2'd2, v); chk("R1 addr", v, 16'h0);
        rd(2'd3, v); chk("R1 mask", v, 16'h0);
    endtask

    task automatic t_banks;
        logic [15:0] v;
        wr(2'd0, 16'h81C4);
        chk("R5 trig after ctrl write", 16'(cmp_trig), 16'h1);
        wr(2'd2, 16'h0123);
        chk("R5 no trig on addr write", 16'(cmp_trig), 16'h0);
        wr(2'd3, 16'hF0F0);
        rd(2'd0, v); chk("R6 ctrl readback", v, 16'h01C4);
        chk("R9 part fg", 16'(part_code), 16'h7);
        chk("R8 mode inc", 16'(addr_mode), 16'h1);
        pick(0, 1);
        chk("R2 bg active", 16'(active_bg), 16'h1);
        rd(2'd2, v); chk("R3 bg addr untouched", v, 16'h0);
        rd(2'd3, v); chk("R3 bg mask untouched", v, 16'h0);
        wr(2'd2, 16'h0456);
        wr(2'd0, 16'h8068);
        chk("R9 part bg", 16'(part_code), 16'h1);
        chk("R7 mask2", 16'(mask_sel), 16'h2);
        chk("R8 mode dec", 16'(addr_mode), 16'h2);
        pick(1, 0);
        chk("R2 fg active", 16'(active_bg), 16'h0);
        rd(2'd2, v); chk("R3 fg addr kept", v, 16'h0123);
        chk("R10 part follows fg", 16'(part_code), 16'h7);
        chk("R10 mode follows fg", 16'(addr_mode), 16'h1);
        chk("R10 mask follows fg", 16'(mask_sel), 16'h0);
    endtask

    task automatic t_trig_pulse;
        wr(2'd0, 16'h8000);
        chk("R5 pulse high", 16'(cmp_trig), 16'h1);
        @(posedge clk); #1;
        chk("R5 pulse one cycle", 16'(cmp_trig), 16'h0);
        wr(2'd1, 16'h1234);
        chk("R5 no trig on seg write", 16'(cmp_trig), 16'h0);
    endtask

    task automatic t_decode;
        for (int m = 0; m < 4; m++) begin
            for (int a = 0; a < 4; a++) begin
                wr(2'd0, 16'h8000 | 16'(m << 4) | 16'(a << 2));
                chk("R7 mask decode", 16'(mask_sel), 16'((m == 1 || m == 2) ? m : 0));
                chk("R8 mode decode", 16'(addr_mode), 16'((a == 1 || a == 2) ? a : 0));
            end
        end
    endtask

    task automatic t_collide;
        logic [15:0] v;
        pick(1, 1);
        chk("R2 both selects hold fg", 16'(active_bg), 16'h0);
        @(negedge clk);
        sel_bg = 1; wr_en = 1; wr_sel = 2'd3; wr_data = 16'hA5A5;
        @(posedge clk); #1;
        sel_bg = 0; wr_en = 0;
        chk("R2 switched to bg", 16'(active_bg), 16'h1);
        rd(2'd3, v); chk("R3 bg mask not written", v, 16'h0);
        pick(1, 1);
        chk("R2 both selects hold bg", 16'(active_bg), 16'h1);
        pick(1, 0);
        rd(2'd3, v); chk("R3 fg mask got write", v, 16'hA5A5);
    endtask

    task automatic t_soft;
        logic [15:0] v;
        pick(0, 1);
        wr(2'd2, 16'h0BEE);
        pick(1, 0);
        wr(2'd0, 16'h7FFF);
        chk("R4 no trig", 16'(cmp_trig), 16'h0);
        chk("R4 fg active", 16'(active_bg), 16'h0);
        rd(2'd0, v); chk("R4 fg ctrl cleared", v, 16'h0);
        rd(2'd3, v); chk("R4 fg mask cleared", v, 16'h0);
        rd(2'd1, v); chk("R4 fg seg init", v, SEG_RST);
        chk("R4 part cleared", 16'(part_code), 16'h0);
        pick(0, 1);
        rd(2'd2, v); chk("R4 bg addr cleared", v, 16'h0);
        rd(2'd1, v); chk("R4 bg seg init", v, SEG_RST);
        pick(0, 1);
        wr(2'd0, 16'h0000);
        chk("R4 reset from bg returns fg", 16'(active_bg), 16'h0);
    endtask

    initial begin
        #100_000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        @(negedge clk); rst_n = 1;
        t_reset();
        t_banks();
        t_trig_pulse();
        t_decode();
        t_collide();
        t_soft();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule